// File: doc/BRIEF.md
# Misaligned Access Exception Entry Unit

This unit sits beside the load/store path of a 16-bit processor core. For every word or two-word load or store it forms the effective address from one of six addressing modes, decides whether the access may proceed, and computes the updated base register for the auto-modifying modes. An odd effective address makes the access fail. The unit then suppresses the memory access and the base write-back, and it performs the address-exception entry: it captures the PC and PSW, builds a reduced PSW, and redirects fetch to the address-exception vector.

One case is checked before alignment. A post-decrement store whose base register is the stack pointer (index 15) is an illegal instruction. It raises an illegal-instruction indication and redirects fetch back to the faulting PC, so the PC does not advance. This check wins over the alignment check. Memory, the register file and instruction decode lie outside the unit. The caller supplies the base register value and index, and consumes the address, the enables and the redirect.

Top module: `misalign_trap_unit`

## Requirements
- R1: `effAddr` depends on `reqMode`. Code 0 gives offset plus base, code 1 gives base, codes 2 and 3 give base, code 4 gives offset, and code 5 gives base minus the access size. The access size is 2 for a word and 4 for a two-word access (`reqPair`=1). Codes 6 and 7 act like code 1.
- R2: When `reqValid` is high and `effAddr` bit 0 is 1, `accessEn` and `baseWrEn` are both 0.
- R3: Only bit 0 is checked for alignment. An even address, including a two-word address that is 2 mod 4, gives `accessEn`=1 when the request is valid and not illegal.
- R4: After a misaligned, non-illegal request, `aeTaken` is 1 in the next cycle. `savedPc` and `savedPsw` then hold the request's `curPc` and `curPsw`, and they keep those values until the next address exception.
- R5: On address-exception entry, `newPsw` becomes `curPsw` AND 0x000D. This keeps carry (bit 0), F1 (bit 2) and F0 (bit 3) and clears every other bit.
- R6: In the cycle after an address exception, `redirectEn` is 1 and `redirectPc` is 0x3FF0C.
- R7: `pairAddr` always equals `effAddr` + 2. It is the address of the odd register of a two-word store.
- R8: A valid store with `reqMode`=3 and `baseIdx`=15 is illegal, even if its address is odd. For that request, `accessEn` and `baseWrEn` are 0. In the next cycle, `illTaken` and `redirectEn` are 1, `redirectPc` equals that request's `curPc`, and `aeTaken` is 0. `savedPc`, `savedPsw` and `newPsw` do not change.
- R9: `baseWrEn` is 1 only for a successful access with mode 2, 3 or 5. `baseNext` is base + size for mode 2, base − size for mode 3, and `effAddr` for mode 5.
- R10: While reset is asserted and after it, until the first request, `aeTaken`, `illTaken`, `redirectEn`, `redirectPc`, `savedPc`, `savedPsw` and `newPsw` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Load/store request present this cycle |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqPair | input | 1 | 1 = two-word access, 0 = word access |
| reqMode | input | 3 | Addressing mode code (see R1) |
| baseVal | input | 16 | Base register value (stack pointer for mode 5) |
| offsetVal | input | 16 | Displacement (mode 0) or absolute address (mode 4) |
| baseIdx | input | 4 | Index of the base register |
| curPc | input | 18 | PC of the request |
| curPsw | input | 16 | PSW at the request |
| effAddr | output | 16 | Effective address |
| pairAddr | output | 16 | Address of the second word |
| accessEn | output | 1 | Memory access may proceed |
| baseWrEn | output | 1 | Write `baseNext` to the base register |
| baseNext | output | 16 | Updated base register value |
| aeTaken | output | 1 | Address exception entered (registered pulse) |
| illTaken | output | 1 | Illegal instruction detected (registered pulse) |
| redirectEn | output | 1 | Fetch redirect valid |
| redirectPc | output | 18 | Fetch redirect target |
| savedPc | output | 18 | Backup PC |
| savedPsw | output | 16 | Backup PSW |
| newPsw | output | 16 | PSW to install on exception entry |

## Verification
The assertions assume that `reqValid`, `reqStore`, `reqMode`, `baseIdx`, `curPc` and `curPsw` hold steady around each clock edge. This matters because the registered checks compare against `$past` of those inputs. They also assume nothing about how many cycles separate requests, so back-to-back faults are legal. The stimulus changes inputs only shortly after a rising edge. It mixes directed cases with random requests over modes 0 to 5. The directed cases include odd bases in every mode, two-word accesses at addresses that are 2 mod 4, pre-decrement from odd stack pointers, and illegal stores with odd addresses.

// File: rtl/misalign_trap_pkg.sv
package misalign_trap_pkg;
  typedef enum logic [2:0] {
    MODE_DISP    = 3'd0,
    MODE_IND     = 3'd1,
    MODE_POSTINC = 3'd2,
    MODE_POSTDEC = 3'd3,
    MODE_ABS     = 3'd4,
    MODE_PREDEC  = 3'd5
  } mtu_mode_e;

  typedef struct packed {
    logic accessGo;
    logic baseWr;
    logic takeAe;
    logic takeIll;
  } mtu_strobe_t;
endpackage

// File: rtl/mtu_ctrl.sv
module mtu_ctrl
  import misalign_trap_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int SP_IDX = 15
) (
  input  logic              reqValid,
  input  logic              reqStore,
  input  mtu_mode_e         mode,
  input  logic [IDX_W-1:0]  baseIdx,
  input  logic              addrOdd,
  output mtu_strobe_t       strb
);
  localparam logic [IDX_W-1:0] SpIdx = IDX_W'(SP_IDX);

  logic illegal;
  logic modifies;

  always_comb begin
    illegal  = reqValid && reqStore && (mode == MODE_POSTDEC) && (baseIdx == SpIdx);
    modifies = (mode == MODE_POSTINC) || (mode == MODE_POSTDEC) || (mode == MODE_PREDEC);
    strb.takeIll  = illegal;
    strb.takeAe   = reqValid && !illegal && addrOdd;
    strb.accessGo = reqValid && !illegal && !addrOdd;
    strb.baseWr   = strb.accessGo && modifies;
  end
endmodule

// File: rtl/mtu_dpath.sv
module mtu_dpath
  import misalign_trap_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          PC_W     = 18,
  parameter int          PSW_W    = 16,
  parameter logic [PC_W-1:0]  AE_VEC   = 18'h3FF0C,
  parameter logic [PSW_W-1:0] PSW_KEEP = 16'h000D
) (
  input  logic              clk,
  input  logic              rst,
  input  mtu_mode_e         mode,
  input  logic              reqPair,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] offsetVal,
  input  logic [PC_W-1:0]   curPc,
  input  logic [PSW_W-1:0]  curPsw,
  input  mtu_strobe_t       strb,
  output logic              addrOdd,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] pairAddr,
  output logic [ADDR_W-1:0] baseNext,
  output logic              aeTaken,
  output logic              illTaken,
  output logic              redirectEn,
  output logic [PC_W-1:0]   redirectPc,
  output logic [PC_W-1:0]   savedPc,
  output logic [PSW_W-1:0]  savedPsw,
  output logic [PSW_W-1:0]  newPsw
);
  localparam logic [ADDR_W-1:0] WordStep = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] PairStep = ADDR_W'(4);

  logic [ADDR_W-1:0] stepSz;

  always_comb begin
    stepSz = reqPair ? PairStep : WordStep;
    unique case (mode)
      MODE_DISP:   effAddr = offsetVal + baseVal;
      MODE_ABS:    effAddr = offsetVal;
      MODE_PREDEC: effAddr = baseVal - stepSz;
      default:     effAddr = baseVal;
    endcase
    unique case (mode)
      MODE_POSTINC: baseNext = baseVal + stepSz;
      MODE_POSTDEC: baseNext = baseVal - stepSz;
      MODE_PREDEC:  baseNext = effAddr;
      default:      baseNext = baseVal;
    endcase
    pairAddr = effAddr + WordStep;
    addrOdd  = effAddr[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aeTaken    <= 1'b0;
      illTaken   <= 1'b0;
      redirectEn <= 1'b0;
      redirectPc <= '0;
      savedPc    <= '0;
      savedPsw   <= '0;
      newPsw     <= '0;
    end else begin
      aeTaken    <= strb.takeAe;
      illTaken   <= strb.takeIll;
      redirectEn <= strb.takeAe || strb.takeIll;
      if (strb.takeIll) begin
        redirectPc <= curPc;
      end else if (strb.takeAe) begin
        redirectPc <= AE_VEC;
      end
      if (strb.takeAe) begin
        savedPc  <= curPc;
        savedPsw <= curPsw;
        newPsw   <= curPsw & PSW_KEEP;
      end
    end
  end
endmodule

// File: rtl/misalign_trap_unit.sv
module misalign_trap_unit
  import misalign_trap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PC_W   = 18,
  parameter int PSW_W  = 16,
  parameter int IDX_W  = 4,
  parameter int SP_IDX = 15,
  parameter logic [PC_W-1:0]  AE_VEC   = 18'h3FF0C,
  parameter logic [PSW_W-1:0] PSW_KEEP = 16'h000D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic              reqPair,
  input  logic [2:0]        reqMode,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] offsetVal,
  input  logic [IDX_W-1:0]  baseIdx,
  input  logic [PC_W-1:0]   curPc,
  input  logic [PSW_W-1:0]  curPsw,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] pairAddr,
  output logic              accessEn,
  output logic              baseWrEn,
  output logic [ADDR_W-1:0] baseNext,
  output logic              aeTaken,
  output logic              illTaken,
  output logic              redirectEn,
  output logic [PC_W-1:0]   redirectPc,
  output logic [PC_W-1:0]   savedPc,
  output logic [PSW_W-1:0]  savedPsw,
  output logic [PSW_W-1:0]  newPsw
);
  mtu_mode_e   mode;
  mtu_strobe_t strb;
  logic        addrOdd;

  assign mode     = mtu_mode_e'(reqMode);
  assign accessEn = strb.accessGo;
  assign baseWrEn = strb.baseWr;

  mtu_ctrl #(.IDX_W(IDX_W), .SP_IDX(SP_IDX)) u_ctrl (
    .reqValid(reqValid), .reqStore(reqStore), .mode(mode),
    .baseIdx(baseIdx), .addrOdd(addrOdd), .strb(strb)
  );

  mtu_dpath #(
    .ADDR_W(ADDR_W), .PC_W(PC_W), .PSW_W(PSW_W),
    .AE_VEC(AE_VEC), .PSW_KEEP(PSW_KEEP)
  ) u_dpath (
    .clk(clk), .rst(rst), .mode(mode), .reqPair(reqPair),
    .baseVal(baseVal), .offsetVal(offsetVal), .curPc(curPc), .curPsw(curPsw),
    .strb(strb), .addrOdd(addrOdd), .effAddr(effAddr), .pairAddr(pairAddr),
    .baseNext(baseNext), .aeTaken(aeTaken), .illTaken(illTaken),
    .redirectEn(redirectEn), .redirectPc(redirectPc), .savedPc(savedPc),
    .savedPsw(savedPsw), .newPsw(newPsw)
  );
endmodule

// File: rtl/mtu_checker.sv
module mtu_checker (
  input logic        clk,
  input logic        rst,
  input logic        reqValid,
  input logic        reqStore,
  input logic [2:0]  reqMode,
  input logic [3:0]  baseIdx,
  input logic [17:0] curPc,
  input logic [15:0] curPsw,
  input logic [15:0] effAddr,
  input logic        accessEn,
  input logic        baseWrEn,
  input logic        aeTaken,
  input logic        illTaken,
  input logic        redirectEn,
  input logic [17:0] redirectPc,
  input logic [17:0] savedPc,
  input logic [15:0] savedPsw,
  input logic [15:0] newPsw
);
  logic illReq;
  assign illReq = reqValid && reqStore && (reqMode == 3'd3) && (baseIdx == 4'd15);

  AST_ODD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (reqValid && effAddr[0]) |-> (!accessEn && !baseWrEn)); // R2
  AST_AE_SAVES: assert property (@(posedge clk) disable iff (rst)
    (reqValid && effAddr[0] && !illReq) |=>
      (aeTaken && savedPc == $past(curPc) && savedPsw == $past(curPsw))); // R4
  AST_PSW_KEEP: assert property (@(posedge clk) disable iff (rst)
    aeTaken |-> ((newPsw & ~16'h000D) == 16'h0000)); // R5
  AST_AE_VECTOR: assert property (@(posedge clk) disable iff (rst)
    aeTaken |-> (redirectEn && redirectPc == 18'h3FF0C)); // R6
  AST_ILL_FIRST: assert property (@(posedge clk) disable iff (rst)
    illReq |=> (illTaken && !aeTaken && redirectPc == $past(curPc))); // R8
  AST_ILL_NOACCESS: assert property (@(posedge clk) disable iff (rst)
    illReq |-> (!accessEn && !baseWrEn)); // R8
  AST_ONE_EXC: assert property (@(posedge clk) disable iff (rst)
    $onehot0({aeTaken, illTaken})); // R8
  AST_WB_ON_SUCCESS: assert property (@(posedge clk) disable iff (rst)
    baseWrEn |-> accessEn); // R9
endmodule

bind misalign_trap_unit mtu_checker u_mtu_checker (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqStore(reqStore),
  .reqMode(reqMode), .baseIdx(baseIdx), .curPc(curPc), .curPsw(curPsw),
  .effAddr(effAddr), .accessEn(accessEn), .baseWrEn(baseWrEn),
  .aeTaken(aeTaken), .illTaken(illTaken), .redirectEn(redirectEn),
  .redirectPc(redirectPc), .savedPc(savedPc), .savedPsw(savedPsw),
  .newPsw(newPsw)
);

// File: tb/misalign_trap_unit_bench.sv
`timescale 1ns/1ps
module misalign_trap_unit_bench;
  logic        clk = 0;
  logic        rst = 1;
  logic        reqValid = 0, reqStore = 0, reqPair = 0;
  logic [2:0]  reqMode = 0;
  logic [15:0] baseVal = 0, offsetVal = 0;
  logic [3:0]  baseIdx = 0;
  logic [17:0] curPc = 0;
  logic [15:0] curPsw = 0;
  logic [15:0] effAddr, pairAddr, baseNext, savedPsw, newPsw;
  logic        accessEn, baseWrEn, aeTaken, illTaken, redirectEn;
  logic [17:0] redirectPc, savedPc;

  int checks = 0, failures = 0, cycles = 0;
  bit checking = 0;
  bit done = 0;

  always #10 clk = ~clk;

  misalign_trap_unit u_misalign_trap_unit (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqStore(reqStore),
    .reqPair(reqPair), .reqMode(reqMode), .baseVal(baseVal),
    .offsetVal(offsetVal), .baseIdx(baseIdx), .curPc(curPc), .curPsw(curPsw),
    .effAddr(effAddr), .pairAddr(pairAddr), .accessEn(accessEn),
    .baseWrEn(baseWrEn), .baseNext(baseNext), .aeTaken(aeTaken),
    .illTaken(illTaken), .redirectEn(redirectEn), .redirectPc(redirectPc),
    .savedPc(savedPc), .savedPsw(savedPsw), .newPsw(newPsw)
  );

  // reference model: registered expectations
  logic        mAe = 0, mIll = 0, mRed = 0;
  logic [17:0] mRedPc = 0, mSPc = 0;
  logic [15:0] mSPsw = 0, mNPsw = 0;

  function automatic int sizeOf(logic pair);
    return pair ? 4 : 2;
  endfunction

  function automatic logic [15:0] refAddr();
    case (reqMode)
      3'd0: return offsetVal + baseVal;
      3'd4: return offsetVal;
      3'd5: return baseVal - 16'(sizeOf(reqPair));
      default: return baseVal;
    endcase
  endfunction

  function automatic bit refIllegal();
    return reqValid && reqStore && reqMode == 3'd3 && baseIdx == 4'd15;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mAe <= 0; mIll <= 0; mRed <= 0; mRedPc <= 0; mSPc <= 0; mSPsw <= 0; mNPsw <= 0;
    end else begin
      automatic bit ill = refIllegal();
      automatic bit ae  = reqValid && !ill && refAddr()[0];
      mAe  <= ae;
      mIll <= ill;
      mRed <= ae || ill;
      if (ill) mRedPc <= curPc;
      else if (ae) mRedPc <= 18'h3FF0C;
      if (ae) begin
        mSPc <= curPc; mSPsw <= curPsw; mNPsw <= curPsw & 16'h000D;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      automatic logic [15:0] a = refAddr();
      automatic bit ill = refIllegal();
      automatic bit go = reqValid && !ill && !a[0];
      automatic bit mod = (reqMode == 3'd2) || (reqMode == 3'd3) || (reqMode == 3'd5);
      automatic logic [15:0] nb;
      case (reqMode)
        3'd2: nb = baseVal + 16'(sizeOf(reqPair));
        3'd3: nb = baseVal - 16'(sizeOf(reqPair));
        default: nb = a;
      endcase
      chk("R1 effAddr", 32'(effAddr), 32'(a));
      chk("R7 pairAddr", 32'(pairAddr), 32'(a + 16'd2));
      if (reqValid && a[0]) chk("R2 accessEn odd", 32'(accessEn), 0);
      else chk("R3 accessEn", 32'(accessEn), 32'(go));
      chk("R9 baseWrEn", 32'(baseWrEn), 32'(go && mod));
      if (go && mod) chk("R9 baseNext", 32'(baseNext), 32'(nb));
      if (ill) chk("R8 no access", 32'(accessEn), 0);
      chk("R4 aeTaken", 32'(aeTaken), 32'(mAe));
      chk("R4 savedPc", 32'(savedPc), 32'(mSPc));
      chk("R4 savedPsw", 32'(savedPsw), 32'(mSPsw));
      chk("R5 newPsw", 32'(newPsw), 32'(mNPsw));
      chk("R6 redirectEn", 32'(redirectEn), 32'(mRed));
      chk("R6 redirectPc", 32'(redirectPc), 32'(mRedPc));
      chk("R8 illTaken", 32'(illTaken), 32'(mIll));
    end
  end

  task automatic issue(bit st, bit pr, int md, int bv, int ov, int idx, int pc, int psw);
    reqValid = 1; reqStore = st; reqPair = pr; reqMode = 3'(md);
    baseVal = 16'(bv); offsetVal = 16'(ov); baseIdx = 4'(idx);
    curPc = 18'(pc); curPsw = 16'(psw);
    @(posedge clk); #2;
  endtask

  task automatic idle();
    reqValid = 0;
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state observed while reset is held
    chk("R10 aeTaken", 32'(aeTaken), 0);
    chk("R10 illTaken", 32'(illTaken), 0);
    chk("R10 redirectEn", 32'(redirectEn), 0);
    chk("R10 redirectPc", 32'(redirectPc), 0);
    chk("R10 savedPc", 32'(savedPc), 0);
    chk("R10 savedPsw", 32'(savedPsw), 0);
    chk("R10 newPsw", 32'(newPsw), 0);
    rst = 0;
    checking = 1;
    idle();
    // R1/R3: aligned accesses in each mode
    issue(0, 0, 0, 'h4000, 'h0002, 3, 'h100, 'hFFFF);
    issue(0, 0, 1, 'h4000, 0, 10, 'h102, 'h1234);
    issue(1, 0, 2, 'h4000, 0, 10, 'h104, 'h1234);
    issue(1, 1, 3, 'h4008, 0, 10, 'h106, 'h1234);
    issue(0, 1, 4, 0, 'h4000, 0, 'h108, 'h1234);
    issue(1, 0, 5, 'h4000, 0, 15, 'h10A, 'h1234);
    issue(1, 1, 5, 'h4004, 0, 15, 'h10C, 'h1234);
    // R3: two-word at 2 mod 4 is legal
    issue(0, 1, 1, 'h4002, 0, 4, 'h10E, 0);
    // R2/R4/R5/R6: misaligned in each mode
    issue(0, 0, 0, 'h4001, 'h0002, 10, 'h200, 'hFFFF);
    issue(0, 1, 1, 'h4001, 0, 10, 'h202, 'h800D);
    issue(1, 0, 2, 'h4001, 0, 10, 'h204, 'h00F2);
    issue(0, 1, 3, 'h4001, 0, 10, 'h206, 'h5555);
    issue(1, 1, 4, 0, 'h4001, 0, 'h208, 'hAAAA);
    issue(1, 0, 5, 'h4001, 0, 15, 'h20A, 'h0008);
    issue(1, 1, 5, 'h4005, 0, 15, 'h20C, 'h0004);
    idle();
    // R8: illegal post-decrement store via index 15, odd and even
    issue(1, 0, 3, 'h4001, 0, 15, 'h300, 'hFFFF);
    issue(1, 1, 3, 'h4000, 0, 15, 'h302, 'hFFFF);
    // R8 boundary: load with the same mode/index is legal
    issue(0, 0, 3, 'h4000, 0, 15, 'h304, 0);
    idle();
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 4) == 0) idle();
      else issue(1'($urandom), 1'($urandom), $urandom_range(0, 5), $urandom, $urandom,
                 $urandom_range(0, 15), $urandom, $urandom);
    end
    idle();
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule